// File: doc/BRIEF.md
# Floor-Rounding Float-to-Integer Converter

This block turns floating-point values into 32-bit integers, always rounding toward negative infinity. It sits in an execution pipeline as a single-stage unit. Operands arrive with a valid strobe. The result register loads on the next clock edge, and a matching valid strobe comes out with it.

In scalar mode the unit reads one operand in half, single or double precision and writes one 32-bit integer. In vector mode the 128-bit operand holds four single-precision lanes. Each lane converts on its own into the matching 32-bit lane of the result. A select input picks two's-complement or unsigned output. Values outside the output range clamp to the nearest end of that range. NaN inputs give zero. The unit produces no flags.

Top module: `fcvt_floor`

## Requirements
- R1: Every conversion returns the largest integer not greater than the input value: 1.5 gives 1, -1.5 gives -2, -0.25 gives -1 (signed).
- R2: In scalar mode (vec_mode=0) fmt_sel picks the source format: 2'b01 half precision in operand[15:0], 2'b10 single in operand[31:0], 2'b11 double in operand[63:0], and 2'b00 is treated as single. The integer appears in result[31:0] and result[127:32] is zero.
- R3: sign_sel=1 gives a two's-complement result and sign_sel=0 an unsigned result, always 32 bits wide.
- R4: With vec_mode=1, lane i of result (bits 32*i+31 down to 32*i) depends only on lane i of operand, read as single precision. fmt_sel has no effect in this mode.
- R5: A value whose floor exceeds the top of the output range, including +infinity, gives 0x7FFFFFFF when signed and 0xFFFFFFFF when unsigned.
- R6: A value whose floor lies below the bottom of the output range, including -infinity, gives 0x80000000 when signed and 0 when unsigned. Every negative non-zero input therefore gives 0 when unsigned.
- R7: Any NaN, quiet or signalling, gives 0.
- R8: +0 and -0 give 0. A positive subnormal gives 0. A negative subnormal gives 0xFFFFFFFF when signed.
- R9: out_valid equals in_valid delayed by one clock, and result shows the conversion of the operand accepted one clock earlier. While in_valid is low, result holds its value. Reset clears out_valid and result to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and selects are valid this cycle |
| vec_mode | input | 1 | 1 = four single-precision lanes, 0 = scalar |
| fmt_sel | input | 2 | Scalar source format select |
| sign_sel | input | 1 | 1 = signed result, 0 = unsigned result |
| operand | input | 128 | Source value(s) |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Converted integer(s) |

## Verification
The only state in the block is the output register and its valid bit. A fault in the datapath therefore shows up on the very next out_valid cycle as a wrong lane value. Off-by-one errors at the range edges, a lost fractional carry for negative inputs, or a lane reading from the wrong slice all appear on the first operand that exercises them. That is why the bench uses directed boundary values: exact powers of two, values half a unit either side of the limits, subnormals, both infinities and NaN payloads. A fault in the register or valid path shows up as a result that changes while idle or a strobe that is not aligned with the data, again within one clock.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    localparam int INT_W  = 32;
    localparam int SIG_W  = 64;
    localparam int EXP_W  = 13;

    typedef enum logic [1:0] {
        FMT_RSVD   = 2'b00,
        FMT_HALF   = 2'b01,
        FMT_SINGLE = 2'b10,
        FMT_DOUBLE = 2'b11
    } fmt_e;

    // Decoded source value: sig has the hidden one at the top bit
    typedef struct packed {
        logic                    sign;
        logic                    is_zero;
        logic                    is_sub;
        logic                    is_inf;
        logic                    is_nan;
        logic signed [EXP_W-1:0] exp;
        logic [SIG_W-1:0]        sig;
    } unpk_t;

    localparam logic [INT_W-1:0] S_MAX = 32'h7FFF_FFFF;
    localparam logic [INT_W-1:0] S_MIN = 32'h8000_0000;
    localparam logic [INT_W-1:0] U_MAX = 32'hFFFF_FFFF;

endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [63:0] raw,
    input  fmt_e        fmt,
    output unpk_t       u
);

    logic exp_ones;
    logic exp_zero;
    logic frac_nz;

    always_comb begin
        u = '0;
        case (fmt)
            FMT_HALF: begin
                u.sign   = raw[15];
                exp_ones = &raw[14:10];
                exp_zero = ~|raw[14:10];
                frac_nz  = |raw[9:0];
                u.exp    = $signed({8'd0, raw[14:10]} - 13'd15);
                u.sig    = {1'b1, raw[9:0], 53'd0};
            end
            FMT_DOUBLE: begin
                u.sign   = raw[63];
                exp_ones = &raw[62:52];
                exp_zero = ~|raw[62:52];
                frac_nz  = |raw[51:0];
                u.exp    = $signed({2'd0, raw[62:52]} - 13'd1023);
                u.sig    = {1'b1, raw[51:0], 11'd0};
            end
            default: begin
                u.sign   = raw[31];
                exp_ones = &raw[30:23];
                exp_zero = ~|raw[30:23];
                frac_nz  = |raw[22:0];
                u.exp    = $signed({5'd0, raw[30:23]} - 13'd127);
                u.sig    = {1'b1, raw[22:0], 40'd0};
            end
        endcase
        u.is_zero = exp_zero && !frac_nz;
        u.is_sub  = exp_zero && frac_nz;
        u.is_inf  = exp_ones && !frac_nz;
        u.is_nan  = exp_ones && frac_nz;
    end

endmodule

// File: rtl/fcvt_floor_core.sv
module fcvt_floor_core
    import fcvt_pkg::*;
(
    input  unpk_t             u,
    input  logic              is_signed,
    output logic [INT_W-1:0]  res
);

    logic             below_one;
    logic             over_31;
    logic             over_32;
    logic [5:0]       e6;
    logic [INT_W-1:0] int_mag;
    logic [SIG_W-1:0] frac_bits;
    logic             frac_nz;
    logic [INT_W:0]   neg_mag;

    always_comb begin
        below_one = u.is_sub || (u.exp < 0);
        over_32   = !below_one && (u.exp > 13'sd31);
        over_31   = !below_one && (u.exp > 13'sd30);
        e6        = {1'b0, u.exp[4:0]};
        int_mag   = '0;
        frac_bits = '0;
        if (!below_one && !over_32) begin
            int_mag   = INT_W'(u.sig >> (6'd63 - e6));
            frac_bits = u.sig << (e6 + 6'd1);
        end
        frac_nz = below_one ? 1'b1 : |frac_bits;
        neg_mag = {1'b0, int_mag} + {{INT_W{1'b0}}, frac_nz};

        if (u.is_nan || u.is_zero) begin
            res = '0;
        end else if (u.is_inf) begin
            if (u.sign) res = is_signed ? S_MIN : '0;
            else        res = is_signed ? S_MAX : U_MAX;
        end else if (!u.sign) begin
            if (is_signed) res = over_31 ? S_MAX : int_mag;
            else           res = over_32 ? U_MAX : int_mag;
        end else begin
            if (!is_signed)
                res = '0;
            else if (over_32 || (neg_mag > 33'h0_8000_0000))
                res = S_MIN;
            else
                res = INT_W'(0) - neg_mag[INT_W-1:0];
        end
    end

endmodule

// File: rtl/fcvt_floor.sv
module fcvt_floor
    import fcvt_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   vec_mode,
    input  logic [1:0]             fmt_sel,
    input  logic                   sign_sel,
    input  logic [LANES*INT_W-1:0] operand,
    output logic                   out_valid,
    output logic [LANES*INT_W-1:0] result
);

    localparam int DATA_W = LANES * INT_W;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } state_t;

    state_t state_d, state_q;

    logic [INT_W-1:0] lane_res [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [63:0] raw_l;
        fmt_e        fmt_l;
        unpk_t       unp_l;

        if (g == 0) begin : g_first
            always_comb begin
                raw_l = vec_mode ? {32'd0, operand[INT_W-1:0]} : operand[63:0];
                fmt_l = vec_mode ? FMT_SINGLE : fmt_e'(fmt_sel);
            end
        end else begin : g_rest
            always_comb begin
                raw_l = {32'd0, operand[g*INT_W +: INT_W]};
                fmt_l = FMT_SINGLE;
            end
        end

        fcvt_unpack u_unp (
            .raw (raw_l),
            .fmt (fmt_l),
            .u   (unp_l)
        );

        fcvt_floor_core u_core (
            .u         (unp_l),
            .is_signed (sign_sel),
            .res       (lane_res[g])
        );
    end

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = '0;
            for (int i = 0; i < LANES; i++) begin
                if (i == 0 || vec_mode)
                    state_d.res[i*INT_W +: INT_W] = lane_res[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;

endmodule

// File: rtl/fcvt_floor_chk.sv
module fcvt_floor_chk #(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                vec_mode,
    input logic                sign_sel,
    input logic [LANES*32-1:0] operand,
    input logic                out_valid,
    input logic [LANES*32-1:0] result
);

    logic l0_nan;
    logic l0_negnz;
    assign l0_nan   = (&operand[30:23]) && (|operand[22:0]);
    assign l0_negnz = operand[31] && (|operand[30:0]) && !l0_nan;

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R2
    scalar_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vec_mode) |=> (result[LANES*32-1:32] == '0));

    // R7
    nan_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_mode && l0_nan) |=> (result[31:0] == 32'd0));

    // R6
    unsigned_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vec_mode && !sign_sel && l0_negnz) |=> (result[31:0] == 32'd0));

endmodule

bind fcvt_floor fcvt_floor_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/tb_fcvt_floor.sv
module tb_fcvt_floor;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         vec_mode = 1'b0;
    logic [1:0]   fmt_sel = 2'b10;
    logic         sign_sel = 1'b1;
    logic [127:0] operand = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        logic [127:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fcvt_floor dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .vec_mode(vec_mode),
        .fmt_sel(fmt_sel), .sign_sel(sign_sel), .operand(operand),
        .out_valid(out_valid), .result(result)
    );

    function automatic real pow2(int k);
        real r = 1.0;
        if (k >= 0) repeat (k) r = r * 2.0;
        else        repeat (-k) r = r / 2.0;
        return r;
    endfunction

    // Reference: decode to real, floor, clamp (R1, R3, R5-R8)
    function automatic logic [31:0] ref_conv(logic [63:0] raw, logic [1:0] fmt, logic sgn);
        int ew, fw, bias;
        logic [63:0] ex, fr;
        logic s;
        real v, fl;
        case (fmt)
            2'b01:   begin ew = 5;  fw = 10; bias = 15;   end
            2'b11:   begin ew = 11; fw = 52; bias = 1023; end
            default: begin ew = 8;  fw = 23; bias = 127;  end
        endcase
        s  = raw[ew+fw];
        ex = (raw >> fw) & ((64'd1 << ew) - 64'd1);
        fr = raw & ((64'd1 << fw) - 64'd1);
        if (ex == ((64'd1 << ew) - 64'd1)) begin
            if (fr != 0) return 32'd0;
            if (s) return sgn ? 32'h8000_0000 : 32'd0;
            return sgn ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
        end
        if (ex == 0) v = real'(fr) * pow2(1 - bias - fw);
        else         v = (real'(fr) + pow2(fw)) * pow2(int'(ex) - bias - fw);
        if (s) v = -v;
        fl = $floor(v);
        if (sgn) begin
            if (fl >= 2147483648.0)  return 32'h7FFF_FFFF;
            if (fl < -2147483648.0)  return 32'h8000_0000;
            return 32'(longint'(fl));
        end
        if (fl < 0.0)            return 32'd0;
        if (fl >= 4294967296.0)  return 32'hFFFF_FFFF;
        return 32'(longint'(fl));
    endfunction

    task automatic send(input logic vm, input logic [1:0] fmt, input logic sgn,
                        input logic [127:0] op, input string tag);
        item_t it;
        it.tag = tag;
        if (vm) begin
            for (int i = 0; i < 4; i++)
                it.exp[i*32 +: 32] = ref_conv({32'd0, op[i*32 +: 32]}, 2'b10, sgn);
        end else begin
            it.exp = {96'd0, ref_conv(op[63:0], fmt, sgn)};
        end
        @(negedge clk);
        sb_q.push_back(it);
        in_valid = 1'b1;
        vec_mode = vm;
        fmt_sel  = fmt;
        sign_sel = sgn;
        operand  = op;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand  = {$urandom, $urandom, $urandom, $urandom};
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R9 unexpected out_valid", {127'd0, out_valid}, 128'd0);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                chk(result === it.exp, it.tag, result, it.exp);
            end
        end
    end

    // Random value near the integer range for a given format
    function automatic logic [63:0] near_rand(logic [1:0] fmt);
        logic [63:0] r;
        int e;
        r = {$urandom, $urandom};
        case (fmt)
            2'b01: begin e = 15 + int'($urandom_range(0, 20)) - 3;
                         return {48'd0, r[0], 5'(e), r[12:3]}; end
            2'b11: begin e = 1023 + int'($urandom_range(0, 40)) - 5;
                         return {r[63], 11'(e), r[51:0]}; end
            default: begin e = 127 + int'($urandom_range(0, 40)) - 5;
                         return {32'd0, r[31], 8'(e), r[22:0]}; end
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : stim
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(out_valid === 1'b0 && result === '0, "R9 reset", {out_valid, result[126:0]}, 128'd0);
        rst_n = 1'b1;
        idle(2);

        // R1 floor rounding, single/half/double
        send(0, 2'b10, 1, 128'h3FC0_0000, "R1 1.5");
        send(0, 2'b10, 1, 128'hBFC0_0000, "R1 -1.5");
        send(0, 2'b10, 1, 128'hBE80_0000, "R1 -0.25");
        send(0, 2'b01, 1, 128'hBE00, "R2 half -1.5");
        send(0, 2'b01, 1, 128'h7BFF, "R2 half max");
        send(0, 2'b11, 1, 128'hC004_0000_0000_0000, "R2 double -2.5");
        send(0, 2'b00, 1, 128'hFFFF_FFFF_C0A0_0000, "R2 fmt 00 as single");
        send(0, 2'b10, 0, 128'h4F00_0000, "R3 unsigned 2^31");
        send(0, 2'b11, 0, 128'h41EF_FFFF_FFE0_0000, "R3 unsigned 2^32-1");
        // R5 upper saturation
        send(0, 2'b10, 1, 128'h4F00_0000, "R5 signed 2^31");
        send(0, 2'b10, 0, 128'h4F80_0000, "R5 unsigned 2^32");
        send(0, 2'b11, 1, 128'h41DF_FFFF_FFE0_0000, "R5 2^31-0.5 not sat");
        send(0, 2'b10, 1, 128'h7F80_0000, "R5 +inf signed");
        send(0, 2'b01, 0, 128'h7C00, "R5 half +inf unsigned");
        // R6 lower saturation
        send(0, 2'b11, 1, 128'hC1E0_0000_0000_0000, "R6 -2^31 exact");
        send(0, 2'b11, 1, 128'hC1E0_0000_0010_0000, "R6 -2^31-0.5");
        send(0, 2'b10, 1, 128'hFF80_0000, "R6 -inf signed");
        send(0, 2'b10, 0, 128'hFF80_0000, "R6 -inf unsigned");
        send(0, 2'b10, 0, 128'hBE80_0000, "R6 -0.25 unsigned");
        // R7 NaN
        send(0, 2'b10, 1, 128'h7FC0_0000, "R7 qnan");
        send(0, 2'b10, 0, 128'hFF80_0001, "R7 snan");
        send(0, 2'b01, 1, 128'h7C01, "R7 half nan");
        send(0, 2'b11, 1, 128'hFFF8_0000_0000_0000, "R7 double nan");
        // R8 zeros and subnormals
        send(0, 2'b10, 1, 128'h0000_0000, "R8 +0");
        send(0, 2'b10, 1, 128'h8000_0000, "R8 -0");
        send(0, 2'b10, 1, 128'h0000_0001, "R8 +sub");
        send(0, 2'b10, 1, 128'h8000_0001, "R8 -sub signed");
        send(0, 2'b11, 1, 128'h8000_0000_0000_0001, "R8 double -sub");
        send(0, 2'b01, 0, 128'h8001, "R8 half -sub unsigned");
        // R4 vector lanes, fmt_sel ignored
        send(1, 2'b01, 1, {32'h3FC0_0000, 32'h4F80_0000, 32'h7FC0_0000, 32'hBFC0_0000}, "R4 mixed lanes");
        send(1, 2'b11, 0, {32'hBF80_0000, 32'h4F7F_FFFF, 32'h0000_0000, 32'h4120_0000}, "R4 unsigned lanes");
        send(1, 2'b00, 1, {32'hFF80_0000, 32'h8000_0001, 32'hCF00_0000, 32'hCF00_0001}, "R4 low lanes");

        // Random sweeps, all formats and modes
        for (int k = 0; k < 300; k++) begin
            logic [1:0] f;
            logic sg;
            f  = 2'($urandom_range(1, 3));
            sg = 1'($urandom);
            send(0, f, sg, {64'($urandom), near_rand(f)}, "R1 random scalar near");
            send(0, f, sg, {$urandom, $urandom, $urandom, $urandom}, "R2 random scalar bits");
            send(1, f, sg, {near_rand(2'b10)[31:0], $urandom, near_rand(2'b10)[31:0], $urandom},
                 "R4 random vector");
            if (k % 5 == 0) idle(1);
        end
        idle(2);

        // R9 hold while idle
        held = result;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            vec_mode = 1'b1;
            operand  = {$urandom, $urandom, $urandom, $urandom};
            #1;
            chk(result === held && out_valid === 1'b0, "R9 hold idle", result, held);
        end
        chk(sb_q.size() == 0, "R9 scoreboard drained", 128'(sb_q.size()), 128'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule